// File: doc/BRIEF.md
# Gated pulse-count frequency meter

This block measures the frequency of a fast, free-running square wave against a slow reference clock, on request. A measurement powers up the analog source that makes the square wave. The block can wait a configurable number of reference cycles for that source to settle. It then counts rising edges of the square wave during exactly one reference period. At the end it powers the source back down and presents the count. With a 32.768 kHz reference, the result is the input frequency divided by 32768. A 2 MHz input therefore reads about 61, and the usual 1.7 to 3.1 MHz range maps to roughly 52 to 95.

Counting runs in the square wave's own clock domain. The window enable enters that domain through a two-flop synchronizer. The synchronized enable returns through a second synchronizer, and the control logic takes the count only after it has seen that round trip rise and then fall. When the round trip is complete the count is stable, so it crosses as a quasi-static bus.

Top module: `freq_meter`

## Requirements
- R1: While rst_ni is low and after it is released, pwr_en_o and done_o are 0 and count_o is 0.
- R2: When req_i is high at a clk_i rising edge while the block is idle, pwr_en_o goes high at that edge. It stays high until the edge where done_o rises, and goes low at that same edge.
- R3: The counting window opens at the clk_i edge SETTLE_CYC cycles after the edge that raised pwr_en_o. done_o rises at the fourth clk_i edge after the window opens.
- R4: count_o becomes the number of sig_i rising edges that fall strictly between the window-opening clk_i edge and the next clk_i edge.
- R5: When more than 2^CNT_W-1 edges fall in the window, count_o is 2^CNT_W-1 (255 by default). The count does not wrap.
- R6: done_o is high for exactly one clk_i cycle per measurement.
- R7: count_o changes only at the edge where done_o rises. Between measurements it holds the last result.
- R8: A req_i pulse while a measurement is in progress has no effect. Only one done_o pulse follows, and pwr_en_o stays low after completion while req_i is low.
- R9: Each measurement starts counting from zero. A low-frequency measurement that follows a saturated one reports its own count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock that defines the counting window |
| rst_ni | input | 1 | Asynchronous active-low reset for both domains |
| req_i | input | 1 | Measurement request, sampled while idle |
| sig_i | input | 1 | Fast square wave to be counted |
| pwr_en_o | output | 1 | Power enable for the analog source |
| done_o | output | 1 | One-cycle completion strobe |
| count_o | output | CNT_W (8) | Latched edge count of the last measurement |

## Verification
Two things are hardest to reach from the ports: an exact count across the two clock domains, and the window position after settling. The result depends on where sig_i edges fall relative to the window-opening edge. The bench therefore restarts the square wave at a known phase for every measurement and computes the expected count from the edge times. Each restart uses an odd picosecond offset against an even period, so no edge ever coincides with a reference edge. A period sweep includes ratios that are not integers, which makes the count sensitive to the settle delay. Very fast periods drive the counter into saturation, and a slow measurement right after them confirms the counter clears.

// File: rtl/fm_pkg.sv
`timescale 1ps/1ps
package fm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_WINDOW,
    ST_WAIT_HI,
    ST_WAIT_LO
  } fm_state_e;
endpackage

// File: rtl/fm_sync.sv
`timescale 1ps/1ps
module fm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/fm_edge_counter.sv
`timescale 1ps/1ps
module fm_edge_counter #(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             sig_i,
  input  logic             rst_ni,
  input  logic             win_i,
  output logic             open_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             en_s;
  logic             en_d;
  logic [CNT_W-1:0] cnt_q;

  fm_sync #(.STAGES(SYNC_STAGES)) u_win_sync (
    .clk_i (sig_i),
    .rst_ni(rst_ni),
    .d_i   (win_i),
    .q_o   (en_s)
  );

  // first edge of a window restarts at one; later edges saturate
  always_ff @(posedge sig_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_d  <= 1'b0;
      cnt_q <= '0;
    end else begin
      en_d <= en_s;
      if (en_s) begin
        if (!en_d)                cnt_q <= CNT_W'(1);
        else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign open_o = en_s;
  assign cnt_o  = cnt_q;

  p_sat_hold_r5: assert property (@(posedge sig_i) disable iff (!rst_ni)
    (en_s && en_d && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));

  p_no_wrap_r5: assert property (@(posedge sig_i) disable iff (!rst_ni)
    (en_s && en_d) |=> (cnt_q != '0));

  p_clear_r9: assert property (@(posedge sig_i) disable iff (!rst_ni)
    (en_s && !en_d) |=> (cnt_q == CNT_W'(1)));
endmodule

// File: rtl/fm_ctrl.sv
`timescale 1ps/1ps
module fm_ctrl
  import fm_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int SETTLE_CYC = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             ack_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             pwr_o,
  output logic             win_o,
  output logic             done_o,
  output logic [CNT_W-1:0] count_o
);
  localparam int TMR_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
  localparam int LAST  = (SETTLE_CYC > 0) ? SETTLE_CYC - 1 : 0;

  fm_state_e        state_q;
  logic [TMR_W-1:0] tmr_q;
  logic             pwr_q, win_q, done_q;
  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      tmr_q   <= '0;
      pwr_q   <= 1'b0;
      win_q   <= 1'b0;
      done_q  <= 1'b0;
      count_q <= '0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (req_i) begin
          pwr_q <= 1'b1;
          tmr_q <= '0;
          if (SETTLE_CYC == 0) begin
            win_q   <= 1'b1;
            state_q <= ST_WINDOW;
          end else begin
            state_q <= ST_SETTLE;
          end
        end
        ST_SETTLE: begin
          if (tmr_q == TMR_W'(LAST)) begin
            win_q   <= 1'b1;
            state_q <= ST_WINDOW;
          end else begin
            tmr_q <= tmr_q + TMR_W'(1);
          end
        end
        ST_WINDOW: begin
          win_q   <= 1'b0;
          state_q <= ST_WAIT_HI;
        end
        // wait for the enable round trip to rise and fall: count is then frozen
        ST_WAIT_HI: if (ack_i) state_q <= ST_WAIT_LO;
        ST_WAIT_LO: if (!ack_i) begin
          pwr_q   <= 1'b0;
          done_q  <= 1'b1;
          count_q <= cnt_i;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign pwr_o   = pwr_q;
  assign win_o   = win_q;
  assign done_o  = done_q;
  assign count_o = count_q;

  p_done_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);

  p_done_drops_pwr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> (!pwr_q && $past(pwr_q)));

  p_win_powered_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_q |-> pwr_q);

  p_win_one_cycle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_q |=> !win_q);

  p_count_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(count_q) |-> done_q);

  p_start_from_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwr_q) |-> $past(state_q == ST_IDLE));
endmodule

// File: rtl/freq_meter.sv
`timescale 1ps/1ps
module freq_meter #(
  parameter int CNT_W       = 8,
  parameter int SETTLE_CYC  = 0,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             sig_i,
  output logic             pwr_en_o,
  output logic             done_o,
  output logic [CNT_W-1:0] count_o
);
  logic             win;
  logic             open_sig;
  logic             ack;
  logic [CNT_W-1:0] cnt;

  fm_ctrl #(.CNT_W(CNT_W), .SETTLE_CYC(SETTLE_CYC)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req_i),
    .ack_i  (ack),
    .cnt_i  (cnt),
    .pwr_o  (pwr_en_o),
    .win_o  (win),
    .done_o (done_o),
    .count_o(count_o)
  );

  fm_edge_counter #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_cnt (
    .sig_i (sig_i),
    .rst_ni(rst_ni),
    .win_i (win),
    .open_o(open_sig),
    .cnt_o (cnt)
  );

  fm_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (open_sig),
    .q_o   (ack)
  );
endmodule

// File: tb/sim_freq_meter.sv
`timescale 1ps/1ps
module sim_freq_meter;
  localparam int  SETTLE = 2;
  localparam longint T   = 10000;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       req_i = 1'b0;
  logic       sig_i = 1'b0;
  logic       pwr_en_o, done_o;
  logic [7:0] count_o;

  int  total = 0;
  int  bad = 0;
  int  prev = 0;
  int  sig_p = 1000;
  bit  gen_stop = 1'b1;
  event gen_go;

  freq_meter #(.CNT_W(8), .SETTLE_CYC(SETTLE), .SYNC_STAGES(2)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .sig_i(sig_i),
    .pwr_en_o(pwr_en_o), .done_o(done_o), .count_o(count_o)
  );

  always #5000 clk_i = ~clk_i;

  // square wave restarts 7 ps after each trigger, period sig_p (even)
  initial begin
    forever begin
      @(gen_go);
      #7;
      while (!gen_stop) begin
        sig_i = 1'b1;
        #(sig_p / 2);
        sig_i = 1'b0;
        #(sig_p / 2);
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic measure(input int p, input bit poke);
    longint s, w, e;
    int n;
    @(negedge clk_i);
    gen_stop = 1'b1;
    repeat (2) @(negedge clk_i);
    sig_p = p;
    gen_stop = 1'b0;
    s = $time;
    ->gen_go;
    req_i = 1'b1;
    w = s + 5000 + SETTLE * T;
    n = 0;
    for (int k = 0; k < 4000; k++) begin
      e = s + 7 + longint'(k) * p;
      if (e > w && e < w + T) n++;
    end
    if (n > 255) n = 255;
    for (int j = 1; j <= SETTLE + 9; j++) begin
      @(negedge clk_i);
      if (j == 1) req_i = 1'b0;
      if (poke && j == 2) req_i = 1'b1;
      if (poke && j == 3) req_i = 1'b0;
      if (j == 1) check("R2 pwr rise", int'(pwr_en_o), 1);
      if (j == SETTLE + 4) begin
        check("R3 done not early", int'(done_o), 0);
        check("R2 pwr held", int'(pwr_en_o), 1);
        check("R7 hold previous", int'(count_o), prev);
      end
      if (j == SETTLE + 5) begin
        check("R3 done timing", int'(done_o), 1);
        check("R2 pwr drop", int'(pwr_en_o), 0);
        check(n == 255 ? "R5 saturated count" : "R4 count", int'(count_o), n);
      end
      if (j == SETTLE + 6) check("R6 done width", int'(done_o), 0);
      if (j > SETTLE + 6) begin
        check(poke ? "R8 ignored request" : "R8 stays idle", int'(pwr_en_o), 0);
        check("R8 no second done", int'(done_o), 0);
        check("R7 hold result", int'(count_o), n);
      end
    end
    prev = n;
  endtask

  initial begin
    #(T * 150000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 reset pwr", int'(pwr_en_o), 0);
    check("R1 reset done", int'(done_o), 0);
    check("R1 reset count", int'(count_o), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    check("R1 idle pwr", int'(pwr_en_o), 0);
    check("R1 idle count", int'(count_o), 0);

    measure(1000, 1'b0);
    measure(164, 1'b1);   // about 61, the 2 MHz case
    measure(200, 1'b0);
    measure(100, 1'b0);
    measure(40, 1'b0);
    measure(38, 1'b0);    // R5 above full scale
    measure(20, 1'b1);    // R5 far above full scale
    measure(400, 1'b0);   // R9 clears after saturation
    measure(2000, 1'b0);
    measure(122, 1'b1);
    // sweep across the working range, non-integer ratios included
    for (int p = 104; p <= 196; p += 6) measure(p, p % 4 == 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule